// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This controller guards a battery-backed static memory against supply loss. Three comparator outputs reach it as synchronous digital flags: the supply is under the upper deselect threshold, under the lower deselect threshold, or under the battery switchover level. Each flag is synchronized and debounced. A four-state sequencer (NORMAL, PROTECT, BATTERY, RECOVER) then drives write protection, a high-impedance enable for the memory data outputs, and a battery-select line for the external power switch.

The deselect threshold sits nominally near 2.85 V, somewhere in a 2.7 V to 3.0 V range, and the switchover level lies about 100 mV below it. After power returns, protection holds for a recovery interval measured in clock cycles. That interval is 40 ms to 200 ms, or 20 ms minimum on the extended-temperature grade. A collapse so fast that the window between the two deselect thresholds is never seen is handled through a deferred path: protection then asserts only after a programmable delay, up to 200 µs.

A bus master stalls on `ready_o`. The write strobe toward the array passes only while the sequencer stays in NORMAL. A write in progress is cut off at the edge where protection asserts, and no new write can begin while protection holds.

Top module: `pfws_sequencer`

## Requirements
- R1: While `rst` is high, the outputs after each rising edge are: `protect_o`=1, `out_hiz_o`=1, `ready_o`=0, `batt_sel_o`=0, `wr_en_o`=0, and `status_o`=2'b01 (PROTECT).
- R2: Each raw flag passes through two synchronizer flops and a filter. The filter takes a new level only after FILT_CYCLES consecutive samples that differ from its current level. A pulse shorter than FILT_CYCLES cycles has no effect on any output.
- R3: In NORMAL, if the upper flag alone becomes active, the next state is PROTECT. `protect_o` and `out_hiz_o` both rise, and `ready_o` falls, at the FILT_CYCLES+3rd rising edge that samples the flag. `protect_o` always equals `out_hiz_o`.
- R4: While protected (PROTECT), an active filtered switchover flag moves the block to BATTERY (`status_o`=2'b10) with `batt_sel_o`=1. When that flag clears, the block returns to PROTECT and `batt_sel_o`=0. `batt_sel_o` is never high without `protect_o`.
- R5: While the filtered lower flag is active, the block never enters NORMAL from a protected state.
- R6: NORMAL (`status_o`=2'b00) is entered only from RECOVER (`status_o`=2'b11). This happens after RECOV_CYCLES rising edges in RECOVER with the filtered upper flag inactive. PROTECT moves to RECOVER once the filtered upper flag is inactive.
- R7: If the filtered upper flag becomes active during RECOVER, the state stays RECOVER and the recovery count restarts from zero.
- R8: In NORMAL, if the filtered lower flag becomes active (a collapse that skipped the window), the state stays NORMAL for DEFER_CYCLES further edges and then moves to PROTECT.
- R9: `wr_en_o` is `wr_req_i`, registered, and only when the next state is NORMAL. It drops at the same edge that `protect_o` rises.
- R10: `ready_o` is high exactly when `status_o`=2'b00, and it is never high together with `protect_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| below_upper_i | input | 1 | Supply under upper deselect threshold |
| below_lower_i | input | 1 | Supply under lower deselect threshold |
| below_batt_i | input | 1 | Supply under battery switchover level |
| wr_req_i | input | 1 | Write strobe from the bus master |
| wr_en_o | output | 1 | Gated write strobe to the memory array |
| protect_o | output | 1 | Chip deselect / write protect |
| out_hiz_o | output | 1 | Force memory data outputs to high impedance |
| batt_sel_o | output | 1 | Select battery supply in the power switch |
| ready_o | output | 1 | Memory accessible (NORMAL state) |
| status_o | output | 2 | Sequencer state: 00 NORMAL, 01 PROTECT, 10 BATTERY, 11 RECOVER |

## Verification
Two situations are the hardest to reach from the ports. The first is the deferred-protect path: it needs the upper and lower filters to change in the same cycle. The stimulus gets there by stepping the modelled supply level straight from good to below the lower threshold, so both flags rise on one edge. The second is the recovery restart: a dip above the lower threshold inside RECOVER, timed so that the total good time exceeds RECOV_CYCLES while no single stretch does. The bench checks that `ready_o` stays low past the point where a timer that failed to restart would have released it.

// File: rtl/pfws_pkg.sv
package pfws_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'b00,
    ST_PROTECT = 2'b01,
    ST_BATTERY = 2'b10,
    ST_RECOVER = 2'b11
  } pfws_state_e;

  localparam int NUM_FLAGS = 3;
  localparam int IDX_UPPER = 0;
  localparam int IDX_LOWER = 1;
  localparam int IDX_BATT  = 2;

endpackage

// File: rtl/pfws_flag_filter.sv
module pfws_flag_filter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

  logic          sync_q1;
  logic          sync_q2;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
      filt_o  <= 1'b0;
      run_cnt <= '0;
    end else begin
      sync_q1 <= raw_i;
      sync_q2 <= sync_q1;
      if (sync_q2 != filt_o) begin
        if (run_cnt == CNT_LAST) begin
          filt_o  <= sync_q2;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pfws_fsm.sv
module pfws_fsm
  import pfws_pkg::*;
#(
  parameter int RECOV_CYCLES = 2000000,
  parameter int DEFER_CYCLES = 10000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        up_i,
  input  logic        lo_i,
  input  logic        bt_i,
  output pfws_state_e nxt_o
);
  localparam int RW = $clog2(RECOV_CYCLES + 1);
  localparam int DW = $clog2(DEFER_CYCLES + 1);
  localparam logic [RW-1:0] REC_LAST = RW'(RECOV_CYCLES - 1);
  localparam logic [DW-1:0] DEF_LAST = DW'(DEFER_CYCLES - 1);

  pfws_state_e   state_q, state_d;
  logic [RW-1:0] rec_q, rec_d;
  logic [DW-1:0] def_q, def_d;
  logic          def_on_q, def_on_d;

  always_comb begin
    state_d  = state_q;
    rec_d    = rec_q;
    def_d    = def_q;
    def_on_d = def_on_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (def_on_q) begin
          if (def_q == DEF_LAST) begin
            state_d  = ST_PROTECT;
            def_on_d = 1'b0;
            def_d    = '0;
          end else begin
            def_d = def_q + 1'b1;
          end
        end else if (lo_i) begin
          def_on_d = 1'b1;
          def_d    = '0;
        end else if (up_i) begin
          state_d = ST_PROTECT;
        end
      end
      ST_PROTECT: begin
        if (bt_i) begin
          state_d = ST_BATTERY;
        end else if (!up_i) begin
          state_d = ST_RECOVER;
          rec_d   = '0;
        end
      end
      ST_BATTERY: begin
        if (!bt_i) state_d = ST_PROTECT;
      end
      ST_RECOVER: begin
        if (bt_i) begin
          state_d = ST_BATTERY;
        end else if (up_i) begin
          rec_d = '0;
        end else if (rec_q == REC_LAST) begin
          state_d = ST_NORMAL;
          rec_d   = '0;
        end else begin
          rec_d = rec_q + 1'b1;
        end
      end
      default: state_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_PROTECT;
      rec_q    <= '0;
      def_q    <= '0;
      def_on_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rec_q    <= rec_d;
      def_q    <= def_d;
      def_on_q <= def_on_d;
    end
  end

  assign nxt_o = state_d;
endmodule

// File: rtl/pfws_sequencer.sv
module pfws_sequencer
  import pfws_pkg::*;
#(
  parameter int FILT_CYCLES  = 4,
  parameter int RECOV_CYCLES = 2000000,
  parameter int DEFER_CYCLES = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       below_upper_i,
  input  logic       below_lower_i,
  input  logic       below_batt_i,
  input  logic       wr_req_i,
  output logic       wr_en_o,
  output logic       protect_o,
  output logic       out_hiz_o,
  output logic       batt_sel_o,
  output logic       ready_o,
  output logic [1:0] status_o
);
  logic [NUM_FLAGS-1:0] raw_flags;
  logic [NUM_FLAGS-1:0] filt_flags;
  pfws_state_e          nxt_state;

  assign raw_flags[IDX_UPPER] = below_upper_i;
  assign raw_flags[IDX_LOWER] = below_lower_i;
  assign raw_flags[IDX_BATT]  = below_batt_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    pfws_flag_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw_flags[g]),
      .filt_o(filt_flags[g])
    );
  end

  pfws_fsm #(
    .RECOV_CYCLES(RECOV_CYCLES),
    .DEFER_CYCLES(DEFER_CYCLES)
  ) u_fsm (
    .clk  (clk),
    .rst  (rst),
    .up_i (filt_flags[IDX_UPPER]),
    .lo_i (filt_flags[IDX_LOWER]),
    .bt_i (filt_flags[IDX_BATT]),
    .nxt_o(nxt_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      protect_o  <= 1'b1;
      out_hiz_o  <= 1'b1;
      batt_sel_o <= 1'b0;
      ready_o    <= 1'b0;
      wr_en_o    <= 1'b0;
      status_o   <= ST_PROTECT;
    end else begin
      protect_o  <= (nxt_state != ST_NORMAL);
      out_hiz_o  <= (nxt_state != ST_NORMAL);
      batt_sel_o <= (nxt_state == ST_BATTERY);
      ready_o    <= (nxt_state == ST_NORMAL);
      wr_en_o    <= wr_req_i && (nxt_state == ST_NORMAL);
      status_o   <= nxt_state;
    end
  end
endmodule

// File: rtl/pfws_sequencer_chk.sv
module pfws_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en_o,
  input logic       protect_o,
  input logic       out_hiz_o,
  input logic       batt_sel_o,
  input logic       ready_o,
  input logic [1:0] status_o
);
  AST_RESET_PROTECTED: assert property (@(posedge clk)
    $fell(rst) |-> (protect_o && !ready_o)); // R1

  AST_PROTECT_MATCHES_HIZ: assert property (@(posedge clk) disable iff (rst)
    protect_o == out_hiz_o); // R3

  AST_BATT_NEEDS_PROTECT: assert property (@(posedge clk) disable iff (rst)
    batt_sel_o |-> protect_o); // R4

  AST_NORMAL_VIA_RECOVER: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> ($past(status_o) == 2'b11)); // R6

  AST_WRITE_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> ready_o); // R9

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!protect_o && status_o == 2'b00)); // R10
endmodule

bind pfws_sequencer pfws_sequencer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en_o   (wr_en_o),
  .protect_o (protect_o),
  .out_hiz_o (out_hiz_o),
  .batt_sel_o(batt_sel_o),
  .ready_o   (ready_o),
  .status_o  (status_o)
);

// File: tb/pfws_sequencer_tb.sv
module pfws_sequencer_tb;
  localparam int FILT  = 3;
  localparam int RECOV = 40;
  localparam int DEFER = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_req = 1'b0;
  int   lvl = 0;  // 0 good, 1 window, 2 below lower, 3 below switchover
  logic up, lo, bt;
  logic wr_en, prot, hiz, bsel, rdy;
  logic [1:0] stat;

  assign up = (lvl >= 1);
  assign lo = (lvl >= 2);
  assign bt = (lvl >= 3);

  always #10 clk = ~clk;

  pfws_sequencer #(.FILT_CYCLES(FILT), .RECOV_CYCLES(RECOV), .DEFER_CYCLES(DEFER)) u_dut (
    .clk(clk), .rst(rst), .below_upper_i(up), .below_lower_i(lo), .below_batt_i(bt),
    .wr_req_i(wr_req), .wr_en_o(wr_en), .protect_o(prot), .out_hiz_o(hiz),
    .batt_sel_o(bsel), .ready_o(rdy), .status_o(stat)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_s1[3], m_s2[3], m_f[3], m_run[3];
  int m_st = 1, m_rec = 0, m_def = 0;
  bit m_don = 0, m_wr = 0, started = 0;

  always @(posedge clk) begin
    int nx;
    int raw[3];
    raw[0] = up; raw[1] = lo; raw[2] = bt;
    started = 1;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_run[i] = 0;
      end
      m_st = 1; m_rec = 0; m_def = 0; m_don = 0; m_wr = 0;
    end else begin
      nx = m_st;
      case (m_st)
        0: begin
          if (m_don) begin
            m_def++;
            if (m_def == DEFER) begin nx = 1; m_don = 0; end
          end else if (m_f[1] != 0) begin
            m_don = 1; m_def = 0;
          end else if (m_f[0] != 0) nx = 1;
        end
        1: begin
          if (m_f[2] != 0) nx = 2;
          else if (m_f[0] == 0) begin nx = 3; m_rec = 0; end
        end
        2: if (m_f[2] == 0) nx = 1;
        default: begin
          if (m_f[2] != 0) nx = 2;
          else if (m_f[0] != 0) m_rec = 0;
          else begin
            m_rec++;
            if (m_rec == RECOV) begin nx = 0; m_rec = 0; end
          end
        end
      endcase
      m_wr = wr_req && (nx == 0);
      m_st = nx;
      for (int i = 0; i < 3; i++) begin
        if (m_s2[i] != m_f[i]) begin
          m_run[i]++;
          if (m_run[i] == FILT) begin m_f[i] = m_s2[i]; m_run[i] = 0; end
        end else m_run[i] = 0;
        m_s2[i] = m_s1[i];
        m_s1[i] = raw[i];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk("R3 protect", int'(prot), int'(m_st != 0));
      chk("R3 hiz", int'(hiz), int'(m_st != 0));
      chk("R4 batt_sel", int'(bsel), int'(m_st == 2));
      chk("R10 ready", int'(rdy), int'(m_st == 0));
      chk("R10 status", int'(stat), m_st);
      chk("R9 wr_en", int'(wr_en), int'(m_wr));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    chk("R1 reset protect", int'(prot), 1);
    chk("R1 reset ready", int'(rdy), 0);
    chk("R1 reset status", int'(stat), 1);
    chk("R1 reset batt", int'(bsel), 0);
    rst = 1'b0;
    wr_req = 1'b1;
    wait_cyc(RECOV - 5);
    chk("R6 still recovering", int'(stat), 3);
    wait_cyc(20);
    chk("R6 normal after recovery", int'(stat), 0);
    chk("R9 write passes", int'(wr_en), 1);
    // glitch shorter than filter
    lvl = 1; wait_cyc(FILT - 1); lvl = 0; wait_cyc(12);
    chk("R2 glitch ignored", int'(rdy), 1);
    // slow fall through window
    lvl = 1; wait_cyc(FILT + 2);
    chk("R3 not yet protected", int'(prot), 0);
    wait_cyc(1);
    chk("R3 protect latency", int'(prot), 1);
    chk("R9 write cut", int'(wr_en), 0);
    wait_cyc(10);
    lvl = 2; wait_cyc(20);
    chk("R5 below lower protected", int'(rdy), 0);
    lvl = 3; wait_cyc(20);
    chk("R4 battery selected", int'(bsel), 1);
    chk("R4 battery status", int'(stat), 2);
    lvl = 2; wait_cyc(20);
    chk("R4 battery released", int'(bsel), 0);
    chk("R4 back to protect", int'(stat), 1);
    lvl = 1; wait_cyc(10);
    lvl = 0; wait_cyc(25);
    chk("R6 in recover", int'(stat), 3);
    lvl = 1; wait_cyc(10);
    chk("R7 held in recover", int'(stat), 3);
    lvl = 0; wait_cyc(30);
    chk("R7 timer restarted", int'(rdy), 0);
    wait_cyc(30);
    chk("R7 normal after restart", int'(rdy), 1);
    // fast collapse skipping the window
    lvl = 2; wait_cyc(FILT + 6);
    chk("R8 deferred still ready", int'(rdy), 1);
    wait_cyc(DEFER + 4);
    chk("R8 deferred protect", int'(prot), 1);
    lvl = 0; wait_cyc(RECOV + 20);
    chk("R6 recovered again", int'(rdy), 1);
    // fast collapse straight to battery
    lvl = 3; wait_cyc(DEFER + FILT + 10);
    chk("R4 battery after defer", int'(bsel), 1);
    wr_req = 1'b0;
    lvl = 0; wait_cyc(RECOV + 20);
    chk("R10 final ready", int'(stat), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule